// File: doc/BRIEF.md
# Display RAM Bit-Modify Command Unit

This unit takes commands from a host over an 8-bit parallel register port. Two select lines steer each access: a register-select line picks between the instruction register and the data path, and a read/write line picks the direction. When the instruction register holds one of the two bit-modify codes, a data write names a bit position. The unit then performs a read-modify-write on one byte of an external synchronous display RAM at the current cursor address. It forces the named bit low or high and leaves the other seven bits as they were. After the operation the cursor steps to the next address.

The operation occupies a fixed execution window. Its length is derived from the clock frequency and a nominal time in nanoseconds (36 µs by default). For that whole window a busy flag is raised. The host can poll the flag at any time with a register read. Host writes that arrive while the flag is up are dropped. A separate load input presets the cursor.

Top module: `bitmod_cmd_unit`

## Requirements
- R1: A host write (`bus_sel`=1, `bus_rnw`=0, `bus_rs`=1) latches `bus_wdata` as the instruction code and does not raise busy. Code 0x0E means clear-bit and code 0x0F means set-bit. The code stays latched after an operation finishes, so a later data write on its own repeats the same operation.
- R2: A data write (`bus_sel`=1, `bus_rnw`=0, `bus_rs`=0) carries NB−1 in `bus_wdata[2:0]`. NB=1 selects RAM bit 0 and NB=8 selects RAM bit 7.
- R3: With clear-bit latched, the byte at the cursor address has the selected bit written as 0. All other bits are written back unchanged.
- R4: With set-bit latched, the selected bit is written as 1. All other bits are written back unchanged.
- R5: When an operation finishes, the cursor advances by exactly 1. It wraps from 2^AW−1 to 0.
- R6: A read with `bus_rs`=1 returns {busy, 7'b0} on `bus_rdata` combinationally, in the same cycle. Any other access returns 0x00.
- R7: Busy rises on the clock edge that accepts a triggering data write. It stays high for exactly EXEC_CYC cycles, where EXEC_CYC = CLK_HZ·EXEC_NS/10^9 with a floor of 4.
- R8: While busy is high, instruction writes and data writes have no effect.
- R9: A data write while the latched code is neither 0x0E nor 0x0F starts nothing: busy stays 0, the RAM is not written and the cursor does not move.
- R10: Each operation drives exactly one single-cycle `ram_we` pulse, inside the busy window, at the cursor address. The byte written is the RAM content read back from that address during the same operation.
- R11: A synchronous active-high reset clears busy, the cursor and the instruction code. Because the cleared code is not a bit-modify code, a data write straight after reset is ignored.
- R12: A pulse on `cur_load` while idle sets the cursor to `cur_load_val`. A pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 1 | 1 = instruction/status, 0 = data |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, busy flag on bit 7 |
| cur_load | input | 1 | Cursor preset strobe |
| cur_load_val | input | AW | Cursor preset value |
| cur_addr | output | AW | Current cursor address |
| ram_addr | output | AW | RAM address, follows the cursor |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |

## Verification
The assertions assume that the RAM returns read data one cycle after the address it sees, and that a host access lasts exactly one cycle. The bench meets both assumptions. Its RAM model registers the read of the current address on every edge. Its bus tasks raise `bus_sel` for a single cycle between falling edges. They never mix a cursor preset into the edge that ends an operation. Random operations are issued only after busy has been seen to fall, so every operation starts from a clean idle state.

// File: rtl/bitmod_pkg.sv
package bitmod_pkg;

    localparam logic [7:0] CODE_BITCLR = 8'h0E;
    localparam logic [7:0] CODE_BITSET = 8'h0F;

    typedef enum logic {
        OP_CLR = 1'b0,
        OP_SET = 1'b1
    } bitop_e;

    typedef struct packed {
        bitop_e     op;
        logic [2:0] pos;
    } bitcmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_CAP,
        PH_WR,
        PH_HOLD
    } phase_e;

    function automatic int unsigned exec_cycles(input int unsigned hz, input int unsigned ns);
        longint unsigned c;
        c = (longint'(hz) * longint'(ns)) / 64'd1_000_000_000;
        if (c < 64'd4) c = 64'd4;
        return int'(c);
    endfunction

    function automatic logic is_bit_code(input logic [7:0] code);
        return (code == CODE_BITCLR) || (code == CODE_BITSET);
    endfunction

    function automatic logic [7:0] apply_bit(input logic [7:0] d, input bitcmd_t c);
        logic [7:0] mask;
        mask = 8'b1 << c.pos;
        return (c.op == OP_SET) ? (d | mask) : (d & ~mask);
    endfunction

endpackage

// File: rtl/bitmod_host_if.sv
module bitmod_host_if
    import bitmod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_rnw,
    input  logic       bus_rs,
    input  logic [7:0] bus_wdata,
    input  logic       busy,
    output logic [7:0] bus_rdata,
    output logic       start,
    output bitcmd_t    cmd
);

    logic [7:0] instr_q;
    logic       instr_wr;
    logic       data_wr;

    assign instr_wr = bus_sel && !bus_rnw && bus_rs && !busy;
    assign data_wr  = bus_sel && !bus_rnw && !bus_rs && !busy;

    always_ff @(posedge clk) begin
        if (rst)           instr_q <= 8'h00;
        else if (instr_wr) instr_q <= bus_wdata;
    end

    always_comb begin
        start   = data_wr && is_bit_code(instr_q);
        cmd.op  = instr_q[0] ? OP_SET : OP_CLR;
        cmd.pos = bus_wdata[2:0];
        bus_rdata = (bus_sel && bus_rnw && bus_rs) ? {busy, 7'b0} : 8'h00;
    end

    // R8: code register frozen during execution
    assert_instr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (instr_q == $past(instr_q)));

endmodule

// File: rtl/bitmod_rmw.sv
module bitmod_rmw
    import bitmod_pkg::*;
#(
    parameter int unsigned EXEC_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bitcmd_t    cmd,
    input  logic [7:0] ram_rdata,
    output logic       busy,
    output logic       step,
    output logic       ram_we,
    output logic [7:0] ram_wdata
);

    localparam int CW = $clog2(EXEC_CYC + 1);

    phase_e      phase;
    bitcmd_t     cmd_q;
    logic [7:0]  rd_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            busy  <= 1'b0;
            cnt   <= '0;
            cmd_q <= '0;
            rd_q  <= 8'h00;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CW'(EXEC_CYC - 1);
            cmd_q <= cmd;
            phase <= PH_RD;
        end else if (busy) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else           busy <= 1'b0;
            case (phase)
                PH_RD:   phase <= PH_CAP;
                PH_CAP:  begin rd_q <= ram_rdata; phase <= PH_WR; end
                PH_WR:   phase <= PH_HOLD;
                default: ;
            endcase
            if (cnt == '0) phase <= PH_IDLE;
        end
    end

    assign step      = busy && (cnt == '0);
    assign ram_we    = (phase == PH_WR);
    assign ram_wdata = apply_bit(rd_q, cmd_q);

    // R10: write strobe only inside the busy window, single cycle
    assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);
    assert_we_single_R10: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);
    // R8: no new start accepted while running
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/bitmod_cursor.sv
module bitmod_cursor #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          busy,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst)                addr <= '0;
        else if (step)          addr <= addr + 1'b1;
        else if (load && !busy) addr <= load_val;
    end

    // R12: preset ignored while an operation runs
    assert_load_blocked_R12: assert property (@(posedge clk) disable iff (rst)
        (load && busy && !step) |=> $stable(addr));

endmodule

// File: rtl/bitmod_cmd_unit.sv
module bitmod_cmd_unit
    import bitmod_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned EXEC_NS = 36_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_rnw,
    input  logic          bus_rs,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          cur_load,
    input  logic [AW-1:0] cur_load_val,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] ram_addr,
    input  logic [7:0]    ram_rdata,
    output logic          ram_we,
    output logic [7:0]    ram_wdata
);

    localparam int unsigned EXEC_CYC = exec_cycles(CLK_HZ, EXEC_NS);

    logic    busy;
    logic    start;
    logic    step;
    bitcmd_t cmd;

    bitmod_host_if u_host (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_rnw(bus_rnw), .bus_rs(bus_rs),
        .bus_wdata(bus_wdata), .busy(busy), .bus_rdata(bus_rdata),
        .start(start), .cmd(cmd)
    );

    bitmod_rmw #(.EXEC_CYC(EXEC_CYC)) u_rmw (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd),
        .ram_rdata(ram_rdata), .busy(busy), .step(step),
        .ram_we(ram_we), .ram_wdata(ram_wdata)
    );

    bitmod_cursor #(.AW(AW)) u_cur (
        .clk(clk), .rst(rst), .step(step), .busy(busy),
        .load(cur_load), .load_val(cur_load_val), .addr(cur_addr)
    );

    assign ram_addr = cur_addr;

    // R5: end of busy comes with a single cursor step
    assert_cursor_step_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cur_addr == AW'($past(cur_addr) + 1'b1)));
    // R7: busy only ever starts from a host data write
    assert_busy_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_sel && !bus_rnw && !bus_rs));
    // R6: low status bits read as zero
    always_comb begin
        if (!rst) assert_rdata_low_R6: assert (bus_rdata[6:0] == 7'b0);
    end

endmodule

// File: tb/sim_bitmod_cmd_unit.sv
module sim_bitmod_cmd_unit;

    localparam int AW       = 4;
    localparam int DEPTH    = 1 << AW;
    localparam int EXP_BUSY = 400 / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 0, bus_rnw = 0, bus_rs = 0;
    logic [7:0]    bus_wdata = 0;
    logic [7:0]    bus_rdata;
    logic          cur_load = 0;
    logic [AW-1:0] cur_load_val = 0;
    logic [AW-1:0] cur_addr, ram_addr;
    logic [7:0]    ram_rdata = 0;
    logic          ram_we;
    logic [7:0]    ram_wdata;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    logic [AW-1:0] exp_cur;
    int checks = 0, fails = 0, we_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bitmod_cmd_unit #(.AW(AW), .CLK_HZ(125_000_000), .EXEC_NS(400)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
        .bus_rs(bus_rs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_load(cur_load), .cur_load_val(cur_load_val), .cur_addr(cur_addr),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_we(ram_we),
        .ram_wdata(ram_wdata)
    );

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            we_cnt <= we_cnt + 1;
        end
        ram_rdata <= mem[ram_addr];
    end

    function automatic logic [7:0] model_bit(logic [7:0] d, logic setop, int nb);
        logic [7:0] r = d;
        r[nb-1] = setop;
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic bus_write(logic rs, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rnw = 0; bus_rs = rs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic read_reg(logic rs, output logic [7:0] v);
        bus_sel = 1; bus_rnw = 1; bus_rs = rs;
        #1 v = bus_rdata;
        bus_sel = 0; bus_rnw = 0;
        #1;
    endtask

    task automatic load_cursor(logic [AW-1:0] v);
        @(negedge clk);
        cur_load = 1; cur_load_val = v;
        @(negedge clk);
        cur_load = 0;
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        n = 0;
        read_reg(1, v);
        while (v[7] && n < 2000) begin
            n++;
            @(negedge clk);
            read_reg(1, v);
        end
    endtask

    task automatic run_op(logic [7:0] code, int nb);
        logic [7:0] v;
        int n, w0;
        logic [AW-1:0] a = exp_cur;
        w0 = we_cnt;
        bus_write(1, code);
        read_reg(1, v);
        check(v == 8'h00, "R1 instr write leaves busy low", v, 0);
        bus_write(0, 8'(nb - 1));
        wait_idle(n);
        check(n == EXP_BUSY, "R7 busy length", n, EXP_BUSY);
        exp_mem[a] = model_bit(exp_mem[a], code[0], nb);
        exp_cur = a + 1'b1;
        check(mem[a] == exp_mem[a], code[0] ? "R4 R2 set bit" : "R3 R2 clear bit",
              mem[a], exp_mem[a]);
        check(cur_addr == exp_cur, "R5 cursor step", cur_addr, exp_cur);
        check(we_cnt - w0 == 1, "R10 one write pulse", we_cnt - w0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, w0;
        logic [AW-1:0] a;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        exp_cur = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R11 reset state
        read_reg(1, v);
        check(v == 8'h00, "R11 busy clear after reset", v, 0);
        check(cur_addr == 0, "R11 cursor zero after reset", cur_addr, 0);
        w0 = we_cnt;
        bus_write(0, 8'h03);
        read_reg(1, v);
        check(v == 8'h00, "R11 data write after reset ignored", v, 0);
        repeat (4) @(negedge clk);
        check(we_cnt == w0 && cur_addr == 0, "R11 no RAM write after reset", we_cnt - w0, 0);

        // R9 unknown code
        bus_write(1, 8'h3A);
        bus_write(0, 8'h01);
        read_reg(1, v);
        check(v == 8'h00, "R9 unknown code no busy", v, 0);
        repeat (4) @(negedge clk);
        check(we_cnt == w0, "R9 unknown code no write", we_cnt - w0, 0);
        check(cur_addr == 0, "R9 unknown code cursor kept", cur_addr, 0);

        // R6 data-side read returns zero
        read_reg(0, v);
        check(v == 8'h00, "R6 data read zero", v, 0);

        // R12 preset while idle
        load_cursor(4'd5);
        exp_cur = 4'd5;
        check(cur_addr == 5, "R12 cursor preset", cur_addr, 5);

        // directed corner bits
        run_op(8'h0F, 8);
        run_op(8'h0E, 1);
        run_op(8'h0F, 1);
        run_op(8'h0E, 8);

        // R8 writes and R12 preset while busy
        a = exp_cur;
        w0 = we_cnt;
        bus_write(1, 8'h0F);
        bus_write(0, 8'h03);
        read_reg(1, v);
        check(v == 8'h80, "R6 busy on bit 7", v, 8'h80);
        read_reg(0, v);
        check(v == 8'h00, "R6 data read zero while busy", v, 0);
        bus_write(1, 8'h0E);
        bus_write(0, 8'h05);
        load_cursor(4'd9);
        wait_idle(n);
        exp_mem[a] = model_bit(exp_mem[a], 1'b1, 4);
        exp_cur = a + 1'b1;
        check(we_cnt - w0 == 1, "R8 data write while busy ignored", we_cnt - w0, 1);
        check(mem[a] == exp_mem[a], "R8 only first op applied", mem[a], exp_mem[a]);
        check(cur_addr == exp_cur, "R12 preset while busy ignored", cur_addr, exp_cur);
        a = exp_cur;
        bus_write(0, 8'h02);
        wait_idle(n);
        exp_mem[a] = model_bit(exp_mem[a], 1'b1, 3);
        exp_cur = a + 1'b1;
        check(mem[a] == exp_mem[a], "R8 R1 code kept, set repeats", mem[a], exp_mem[a]);

        // R5 wrap
        load_cursor(4'd15);
        exp_cur = 4'd15;
        run_op(8'h0F, 5);
        check(cur_addr == 0, "R5 cursor wraps", cur_addr, 0);

        // random operations
        for (int k = 0; k < 24; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                exp_cur = AW'($urandom);
                load_cursor(exp_cur);
            end
            run_op(($urandom_range(0, 1) != 0) ? 8'h0F : 8'h0E, int'($urandom_range(1, 8)));
        end

        for (int i = 0; i < DEPTH; i++)
            check(mem[i] == exp_mem[i], "R3 R4 RAM image", mem[i], exp_mem[i]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule